// File: doc/BRIEF.md
# Operate ALU with Condition Codes

This block is the execute stage of a small 16-bit load/store processor. It carries out the three operate functions of the instruction set: two's-complement addition, bitwise AND and bitwise NOT. The instruction word selects the function and the second operand. The second operand is either a second register value or a 5-bit immediate held in the instruction, which is sign-extended before use. The result is combinational. It appears in the same cycle as the inputs, and no carry or overflow is reported.

Next to the arithmetic sits a three-flag condition register. It holds negative, zero and positive, and exactly one of them is set at any time. It loads only on a clock edge where the control unit raises the flag enable. For an operate instruction the flags are taken from this block's own result. For any other instruction that writes a register (the loads and the effective-address instruction), they are taken from the value on the shared result bus. The register file, memory and sequencing sit outside the block.

Top module: `opalu_core`

## Requirements
- R1: With opcode bits [15:12] = 4'b0001, `result` equals `src_a` plus the second operand, modulo 2^16, in the same cycle.
- R2: With opcode 4'b0101, `result` equals `src_a` bitwise AND the second operand.
- R3: With opcode 4'b1001, `result` equals the bitwise inverse of `src_a`. Bit 5, bits [4:0] and `src_b` have no effect.
- R4: For opcodes 4'b0001 and 4'b0101, instruction bit 5 = 0 selects `src_b` as the second operand. Bit 5 = 1 selects bits [4:0], sign-extended from bit 4 to 16 bits.
- R5: For every other opcode, `result` is 16'h0000.
- R6: When `cc_en` is high at a rising clock edge, the flags load the class of the written value: `flag_n` if bit 15 is 1, `flag_z` if the value is zero, and `flag_p` otherwise.
- R7: The written value is `result` when the opcode is one of the three operate opcodes, and `bus_val` for any other opcode.
- R8: When `cc_en` is low at a rising edge, all three flags keep their values.
- R9: While `rst_n` is low, and after its release until the first enabled update, the flags are Z=1, N=0, P=0.
- R10: Exactly one of `flag_n`, `flag_z` and `flag_p` is high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Current instruction word |
| src_a | input | 16 | First register operand |
| src_b | input | 16 | Second register operand |
| bus_val | input | 16 | Value on the result bus for non-operate writes |
| cc_en | input | 1 | Flag register load enable |
| result | output | 16 | Operate result (combinational) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
An operate result and a result-bus value can both be present in the cycle where the flag register loads. Only one of them may decide the flags, and the opcode picks which. The bench provokes this with directed cases that give the ALU result and `bus_val` different classes, for example an ADD that wraps to zero while the bus carries a negative word. It also provokes it with random instructions whose bus values are independent of the result. Each flag update is judged against a bench model that classifies the result for the three operate opcodes and `bus_val` for everything else. The check is made on the falling edge after the enabled rising edge.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
   localparam int INSTR_W  = 16;
   localparam int OPC_HI   = 15;
   localparam int OPC_LO   = 12;
   localparam int MODE_BIT = 5;
   localparam int IMM_W    = 5;
   localparam int OPC_W    = OPC_HI - OPC_LO + 1;

   localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
   localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

   typedef enum logic [1:0] {
      FN_NONE = 2'd0,
      FN_ADD  = 2'd1,
      FN_AND  = 2'd2,
      FN_NOT  = 2'd3
   } fn_e;

   typedef struct packed {
      fn_e              fn;
      logic             use_imm;
      logic [IMM_W-1:0] imm;
   } dec_t;

   typedef struct packed {
      logic neg;
      logic zero;
      logic pos;
   } nzp_t;

   localparam nzp_t NZP_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/opalu_decode.sv
module opalu_decode
   import opalu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  src_b,
   output fn_e                fn,
   output logic               is_operate,
   output logic [DATA_W-1:0]  operand_b
);
   localparam int EXT_W = DATA_W - IMM_W;

   dec_t              dec;
   logic [OPC_W-1:0]  opc;
   logic [DATA_W-1:0] imm_ext;
   logic              unused_fields;

   assign opc = instr[OPC_HI:OPC_LO];
   assign unused_fields = ^{instr[OPC_LO-1:MODE_BIT+1]};

   always_comb begin
      dec.fn      = FN_NONE;
      dec.use_imm = instr[MODE_BIT];
      dec.imm     = instr[IMM_W-1:0];
      unique case (opc)
         OPC_ADD: dec.fn = FN_ADD;
         OPC_AND: dec.fn = FN_AND;
         OPC_NOT: dec.fn = FN_NOT;
         default: dec.fn = FN_NONE;
      endcase
   end

   generate
      if (EXT_W > 0) begin : g_sext
         assign imm_ext = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
      end else begin : g_trunc
         assign imm_ext = dec.imm[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      operand_b = src_b;
      if (dec.fn != FN_NOT && dec.use_imm) operand_b = imm_ext;
   end

   assign fn         = dec.fn;
   assign is_operate = (dec.fn != FN_NONE);
endmodule

// File: rtl/opalu_func.sv
module opalu_func
   import opalu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDER_STYLE = 0
) (
   input  fn_e               fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   logic [DATA_W-1:0] sum;

   generate
      if (ADDER_STYLE == 0) begin : g_add_infer
         assign sum = a + b;
      end else begin : g_add_ripple
         logic [DATA_W:0] carry;
         logic            unused_cout;
         assign carry[0]    = 1'b0;
         assign unused_cout = carry[DATA_W];
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_ADD:  y = sum;
         FN_AND:  y = a & b;
         FN_NOT:  y = ~a;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/opalu_ccreg.sv
module opalu_ccreg
   import opalu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              pick_local,
   input  logic [DATA_W-1:0] local_val,
   input  logic [DATA_W-1:0] bus_val,
   output nzp_t              flags
);
   logic [DATA_W-1:0] wr_val;
   nzp_t              next_cls;

   assign wr_val = pick_local ? local_val : bus_val;

   always_comb begin
      next_cls.neg  = wr_val[DATA_W-1];
      next_cls.zero = (wr_val == '0);
      next_cls.pos  = !wr_val[DATA_W-1] && (wr_val != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flags <= NZP_RESET;
      else if (load) flags <= next_cls;
   end
endmodule

// File: rtl/opalu_core.sv
module opalu_core
   import opalu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] bus_val,
   input  logic              cc_en,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_p
);
   generate
      if (DATA_W < IMM_W + 1) begin : g_bad_width
         $error("opalu_core: DATA_W must exceed the immediate width");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("opalu_core: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   fn_e               fn;
   logic              is_op;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] alu_y;
   nzp_t              flags;

   opalu_decode #(.DATA_W(DATA_W)) u_dec (
      .instr      (instr),
      .src_b      (src_b),
      .fn         (fn),
      .is_operate (is_op),
      .operand_b  (opnd_b)
   );

   opalu_func #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_fn (
      .fn (fn),
      .a  (src_a),
      .b  (opnd_b),
      .y  (alu_y)
   );

   opalu_ccreg #(.DATA_W(DATA_W)) u_cc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cc_en),
      .pick_local (is_op),
      .local_val  (alu_y),
      .bus_val    (bus_val),
      .flags      (flags)
   );

   assign result = alu_y;
   assign flag_n = flags.neg;
   assign flag_z = flags.zero;
   assign flag_p = flags.pos;
endmodule

// File: rtl/opalu_chk.sv
module opalu_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       instr,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [DATA_W-1:0] bus_val,
   input logic              cc_en,
   input logic [DATA_W-1:0] result,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_p
);
   logic [3:0] opc;
   logic       oper;
   assign opc  = instr[15:12];
   assign oper = (opc == 4'b0001) || (opc == 4'b0101) || (opc == 4'b1001);

   assert_add_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 4'b0001 && !instr[5]) |-> result == DATA_W'(src_a + src_b));

   assert_and_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 4'b0101 && !instr[5]) |-> result == (src_a & src_b));

   assert_not_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 4'b1001) |-> result == ~src_a);

   assert_other_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !oper |-> result == '0);

   assert_bus_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_en && !oper && bus_val == '0) |=> flag_z);

   assert_op_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_en && oper) |=> (flag_n == $past(result[DATA_W-1])));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_en |=> $stable({flag_n, flag_z, flag_p}));

   assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flag_z && !flag_n && !flag_p));

   assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flag_n, flag_z, flag_p}) == 1);
endmodule

bind opalu_core opalu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .instr   (instr),
   .src_a   (src_a),
   .src_b   (src_b),
   .bus_val (bus_val),
   .cc_en   (cc_en),
   .result  (result),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_p  (flag_p)
);

// File: tb/opalu_core_bench.sv
module opalu_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] src_a = '0;
   logic [15:0] src_b = '0;
   logic [15:0] bus_val = '0;
   logic        cc_en = 1'b0;
   logic [15:0] result;
   logic        flag_n, flag_z, flag_p;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [2:0] exp_nzp;

   always #10 clk = ~clk;

   opalu_core u_opalu_core (
      .clk(clk), .rst_n(rst_n), .instr(instr), .src_a(src_a), .src_b(src_b),
      .bus_val(bus_val), .cc_en(cc_en), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
   );

   function automatic logic is_oper(input logic [15:0] ins);
      return ins[15:12] == 4'h1 || ins[15:12] == 4'h5 || ins[15:12] == 4'h9;
   endfunction

   function automatic logic [15:0] model_res(input logic [15:0] ins,
                                             input logic [15:0] a,
                                             input logic [15:0] b);
      logic [15:0] op2;
      op2 = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
      case (ins[15:12])
         4'h1:    return a + op2;
         4'h5:    return a & op2;
         4'h9:    return ~a;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [2:0] classify(input logic [15:0] v);
      if (v[15])        return 3'b100;
      else if (v == 0)  return 3'b010;
      else              return 3'b001;
   endfunction

   task automatic check(input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic do_op(input string tag, input logic [15:0] ins,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] bus, input logic en);
      logic [15:0] r;
      instr = ins; src_a = a; src_b = b; bus_val = bus; cc_en = en;
      #1;
      r = model_res(ins, a, b);
      check({tag, " result"}, result, r);
      if (en) exp_nzp = classify(is_oper(ins) ? r : bus);
      @(negedge clk);
      check({tag, " flags"}, {13'd0, flag_n, flag_z, flag_p}, {13'd0, exp_nzp});
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      exp_nzp = 3'b010;
      repeat (3) @(negedge clk);
      check("R9 flags in reset", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 flags after release", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);

      // Directed corners
      do_op("R1 add reg",          16'h1042, 16'd1234, 16'd4321, 16'h0, 1'b1);
      do_op("R1 add wrap to neg",  16'h1000, 16'h7FFF, 16'h0001, 16'h0, 1'b1);
      do_op("R7 add wrap zero vs neg bus", 16'h1000, 16'hFFFF, 16'h0001, 16'h8000, 1'b1);
      do_op("R4 add imm -16",      16'h1030, 16'd5, 16'hAAAA, 16'h0, 1'b1);
      do_op("R4 add imm +15",      16'h102F, 16'd5, 16'hAAAA, 16'h0, 1'b1);
      do_op("R2 and reg",          16'h5001, 16'hF0F0, 16'h3C3C, 16'h0, 1'b1);
      do_op("R2 R4 and imm -1",    16'h503F, 16'h8123, 16'h0000, 16'h0, 1'b1);
      do_op("R2 R4 and imm +1 pos", 16'h5021, 16'h8123, 16'hFFFF, 16'h8000, 1'b1);
      do_op("R3 not ignores b",    16'h903F, 16'h00FF, 16'h1234, 16'h0, 1'b1);
      do_op("R3 not of all ones",  16'h9000, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1);
      do_op("R5 R7 load bus neg",  16'h2000, 16'h1111, 16'h2222, 16'h9000, 1'b1);
      do_op("R7 load bus pos",     16'hA000, 16'h1111, 16'h2222, 16'h0042, 1'b1);
      do_op("R8 hold with zero bus", 16'h2000, 16'h0, 16'h0, 16'h0000, 1'b0);
      do_op("R8 hold with op zero",  16'h5000, 16'h0, 16'h0, 16'h0000, 1'b0);
      do_op("R6 R7 load bus zero", 16'hE000, 16'h7, 16'h7, 16'h0000, 1'b1);
      check("R10 one flag", 16'($countones({flag_n, flag_z, flag_p})), 16'd1);

      // Constrained random
      for (int i = 0; i < 400; i++) begin
         logic [15:0] ins, a, b, bus;
         logic [3:0]  opc;
         logic        en;
         case ($urandom_range(0, 4))
            0: opc = 4'h1;
            1: opc = 4'h5;
            2: opc = 4'h9;
            default: opc = 4'($urandom);
         endcase
         ins = {opc, 12'($urandom)};
         a   = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom);
         b   = ($urandom_range(0, 7) == 0) ? 16'(-a) : 16'($urandom);
         bus = ($urandom_range(0, 5) == 0) ? 16'h0 : 16'($urandom);
         en  = ($urandom_range(0, 3) != 0);
         do_op("R1 R2 R3 R4 R5 R6 R7 R8 random", ins, a, b, bus, en);
         check("R10 one flag random",
               16'($countones({flag_n, flag_z, flag_p})), 16'd1);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule